// File: doc/BRIEF.md
# Output-Port Congestion Tracker with Forward Marking

This block sits beside the queues of one switch input port that holds a single cold queue and a small set of hot queues. It watches the occupancy counts of all of them. When the cold queue fills past a programmed level, it raises a one-cycle request to allocate a hot queue. Each hot queue reports the output port its flow leaves through. The block keeps one congestion flag per output port, with hysteresis between a high and a low threshold.

While an output port's flag is set, every packet departing through that port carries a forward congestion mark. This includes cold packets and not only the flows that caused the congestion. Hot queues keep congested flows from blocking cold traffic, so the mark follows the output port rather than the flow. Queue storage and the flow-to-queue table are outside this block.

Occupancies are counted in flits of 8 bits. The default configuration has 4 output ports, 4 hot queues and 6-bit counts.

Three kinds of state machine are used:
- **Cold-queue machine.** States COLD_ARMED, COLD_PULSE and COLD_WAIT.
  - COLD_ARMED goes to COLD_PULSE when the cold occupancy is above the cold threshold.
  - COLD_PULSE goes to COLD_ARMED if the occupancy is below the threshold, and to COLD_WAIT otherwise.
  - COLD_WAIT goes to COLD_ARMED once the occupancy is below the threshold.
- **Port machine, one per output port.** States PORT_CLEAR and PORT_CONG.
  - PORT_CLEAR goes to PORT_CONG when a valid hot queue mapped to that port is at or above the high threshold.
  - PORT_CONG goes to PORT_CLEAR when no valid hot queue mapped to that port is above the low threshold.
- **Configuration machine.** States CFG_OK and CFG_ERR.
  - A write with low < high moves it to CFG_OK.
  - A write with low >= high moves it to CFG_ERR.

Top module: `fwd_cong_marker`

## Requirements
- R1: After reset, all congestion flags, the allocate request, the mark and the error bit are 0. The thresholds are: cold 10, high 12, low 4.
- R2: When the cold occupancy is strictly greater than the cold threshold while armed, alloc_req is 1 for exactly one cycle, in the cycle after the sampling edge.
- R3: After firing, alloc_req is not raised again until the cold occupancy has been sampled strictly below the cold threshold and later sampled strictly above it. An occupancy equal to the threshold does not re-arm.
- R4: A port in PORT_CLEAR sets its flag at the next edge if any valid hot queue whose hot_port field equals that port index has occupancy >= the high threshold.
- R5: A port in PORT_CONG keeps its flag while any valid hot queue mapped to it has occupancy strictly greater than the low threshold.
- R6: A port in PORT_CONG clears its flag at the next edge once every valid hot queue mapped to it has occupancy <= the low threshold. This includes the case where no queue is mapped to it.
- R7: Hot queues with hot_valid low, or mapped to other ports, have no effect on a port's flag.
- R8: dep_mark equals dep_valid AND the registered flag of the port given by dep_port, in the same cycle. Every packet on a congested port is marked, whatever queue it came from.
- R9: A configuration write with cfg_lo_thr < cfg_hi_thr loads all three thresholds. They take effect from the next cycle, and cfg_err returns to 0.
- R10: A configuration write with cfg_lo_thr >= cfg_hi_thr leaves all three thresholds unchanged and sets cfg_err to 1. cfg_err stays set until a valid write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_cold_thr | input | OCC_W | New cold-queue threshold |
| cfg_hi_thr | input | OCC_W | New high threshold |
| cfg_lo_thr | input | OCC_W | New low threshold |
| cold_occ | input | OCC_W | Cold queue occupancy in flits |
| hot_occ | input | NHOT x OCC_W | Occupancy of each hot queue in flits |
| hot_port | input | NHOT x PORT_W | Output port each hot queue maps to |
| hot_valid | input | NHOT | Hot queue currently allocated |
| dep_valid | input | 1 | Packet departs this cycle |
| dep_port | input | PORT_W | Output port of the departing packet |
| alloc_req | output | 1 | One-cycle hot-queue allocate request |
| cong_flags | output | NOUT | Congestion flag per output port |
| dep_mark | output | 1 | Forward congestion mark for the departing packet |
| cfg_err | output | 1 | Last threshold write was rejected |

## Verification
Results fall due at different times:
- Flag changes and allocate pulses are due one edge after the occupancy that causes them is applied.
- A threshold write is reflected in cfg_err after one edge, and in behaviour from the following sample.
- The mark is combinational on the registered flag, so it is due in the same cycle as the departure strobe.

The bench drives every input on the falling edge. After each rising edge it compares the flags and the allocate request at the next falling edge against an arithmetic model of the thresholds. It then sweeps dep_port across all ports within that same cycle to check the mark before the next edge.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
    typedef enum logic [1:0] {
        COLD_ARMED = 2'd0,
        COLD_PULSE = 2'd1,
        COLD_WAIT  = 2'd2
    } cold_st_e;

    typedef enum logic {
        PORT_CLEAR = 1'b0,
        PORT_CONG  = 1'b1
    } port_st_e;

    typedef enum logic {
        CFG_OK  = 1'b0,
        CFG_ERR = 1'b1
    } cfg_st_e;
endpackage

// File: rtl/fcm_thresh.sv
module fcm_thresh
    import fcm_pkg::*;
#(
    parameter int OCC_W    = 6,
    parameter int DEF_COLD = 10,
    parameter int DEF_HI   = 12,
    parameter int DEF_LO   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [OCC_W-1:0] cfg_cold,
    input  logic [OCC_W-1:0] cfg_hi,
    input  logic [OCC_W-1:0] cfg_lo,
    output logic [OCC_W-1:0] cold_thr,
    output logic [OCC_W-1:0] hi_thr,
    output logic [OCC_W-1:0] lo_thr,
    output logic             cfg_err
);
    cfg_st_e state_q, state_d;
    logic    pair_ok;

    assign pair_ok = (cfg_lo < cfg_hi);

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d = pair_ok ? CFG_OK : CFG_ERR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CFG_OK;
            cold_thr <= OCC_W'(DEF_COLD);
            hi_thr   <= OCC_W'(DEF_HI);
            lo_thr   <= OCC_W'(DEF_LO);
        end else begin
            state_q <= state_d;
            if (cfg_we && pair_ok) begin
                cold_thr <= cfg_cold;
                hi_thr   <= cfg_hi;
                lo_thr   <= cfg_lo;
            end
        end
    end

    always_comb begin
        cfg_err = (state_q == CFG_ERR);
    end

    // R10: a rejected write keeps every threshold and flags the error
    a_r10_hold_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_lo >= cfg_hi)) |=> ($stable(hi_thr) && $stable(lo_thr) && $stable(cold_thr) && cfg_err));

    // R9: the stored pair is always ordered
    a_r9_pair_ordered: assert property (@(posedge clk) disable iff (!rst_n)
        lo_thr < hi_thr);

    // R9: an accepted write clears the error
    a_r9_good_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_lo < cfg_hi)) |=> (!cfg_err && hi_thr == $past(cfg_hi)));
endmodule

// File: rtl/fcm_cold_fsm.sv
module fcm_cold_fsm
    import fcm_pkg::*;
#(
    parameter int OCC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] cold_occ,
    input  logic [OCC_W-1:0] cold_thr,
    output logic             alloc_req
);
    cold_st_e state_q, state_d;
    logic     above, below;

    assign above = (cold_occ > cold_thr);
    assign below = (cold_occ < cold_thr);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            COLD_ARMED: if (above) state_d = COLD_PULSE;
            COLD_PULSE: state_d = below ? COLD_ARMED : COLD_WAIT;
            COLD_WAIT:  if (below) state_d = COLD_ARMED;
            default:    state_d = COLD_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= COLD_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        alloc_req = (state_q == COLD_PULSE);
    end

    // R2: the request never lasts two cycles
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |=> !alloc_req);

    // R3: waiting without a dip below the threshold never fires
    a_r3_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == COLD_WAIT && !below) |=> !alloc_req);
endmodule

// File: rtl/fcm_port_fsm.sv
module fcm_port_fsm
    import fcm_pkg::*;
#(
    parameter int NHOT    = 4,
    parameter int OCC_W   = 6,
    parameter int PORT_W  = 2,
    parameter int PORT_ID = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NHOT-1:0][OCC_W-1:0]  hot_occ,
    input  logic [NHOT-1:0][PORT_W-1:0] hot_port,
    input  logic [NHOT-1:0]             hot_valid,
    input  logic [OCC_W-1:0]            hi_thr,
    input  logic [OCC_W-1:0]            lo_thr,
    output logic                        flag
);
    localparam logic [PORT_W-1:0] MY_PORT = PORT_W'(PORT_ID);

    port_st_e state_q, state_d;
    logic     hit_hi, above_lo;

    always_comb begin
        hit_hi   = 1'b0;
        above_lo = 1'b0;
        for (int q = 0; q < NHOT; q++) begin
            if (hot_valid[q] && (hot_port[q] == MY_PORT)) begin
                if (hot_occ[q] >= hi_thr) hit_hi   = 1'b1;
                if (hot_occ[q] >  lo_thr) above_lo = 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_CLEAR: if (hit_hi)    state_d = PORT_CONG;
            PORT_CONG:  if (!above_lo) state_d = PORT_CLEAR;
            default:    state_d = PORT_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == PORT_CONG);
    end

    // R4: reaching the high threshold sets the flag on the next edge
    a_r4_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && hit_hi) |=> flag);

    // R5: the flag holds while a mapped queue is above the low threshold
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && above_lo) |=> flag);

    // R6: the flag drops once nothing mapped is above the low threshold
    a_r6_leave: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !above_lo) |=> !flag);
endmodule

// File: rtl/fwd_cong_marker.sv
module fwd_cong_marker
    import fcm_pkg::*;
#(
    parameter int NOUT     = 4,
    parameter int NHOT     = 4,
    parameter int OCC_W    = 6,
    parameter int DEF_COLD = 10,
    parameter int DEF_HI   = 12,
    parameter int DEF_LO   = 4,
    localparam int PORT_W  = (NOUT > 1) ? $clog2(NOUT) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [OCC_W-1:0]            cfg_cold_thr,
    input  logic [OCC_W-1:0]            cfg_hi_thr,
    input  logic [OCC_W-1:0]            cfg_lo_thr,
    input  logic [OCC_W-1:0]            cold_occ,
    input  logic [NHOT-1:0][OCC_W-1:0]  hot_occ,
    input  logic [NHOT-1:0][PORT_W-1:0] hot_port,
    input  logic [NHOT-1:0]             hot_valid,
    input  logic                        dep_valid,
    input  logic [PORT_W-1:0]           dep_port,
    output logic                        alloc_req,
    output logic [NOUT-1:0]             cong_flags,
    output logic                        dep_mark,
    output logic                        cfg_err
);
    logic [OCC_W-1:0] cold_thr, hi_thr, lo_thr;

    fcm_thresh #(
        .OCC_W(OCC_W), .DEF_COLD(DEF_COLD), .DEF_HI(DEF_HI), .DEF_LO(DEF_LO)
    ) u_thresh (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_cold(cfg_cold_thr), .cfg_hi(cfg_hi_thr), .cfg_lo(cfg_lo_thr),
        .cold_thr(cold_thr), .hi_thr(hi_thr), .lo_thr(lo_thr), .cfg_err(cfg_err)
    );

    fcm_cold_fsm #(.OCC_W(OCC_W)) u_cold (
        .clk(clk), .rst_n(rst_n), .cold_occ(cold_occ),
        .cold_thr(cold_thr), .alloc_req(alloc_req)
    );

    for (genvar p = 0; p < NOUT; p++) begin : g_port
        fcm_port_fsm #(
            .NHOT(NHOT), .OCC_W(OCC_W), .PORT_W(PORT_W), .PORT_ID(p)
        ) u_port (
            .clk(clk), .rst_n(rst_n), .hot_occ(hot_occ), .hot_port(hot_port),
            .hot_valid(hot_valid), .hi_thr(hi_thr), .lo_thr(lo_thr),
            .flag(cong_flags[p])
        );
    end

    // R8: mark follows the registered flag of the departure port
    always_comb begin
        dep_mark = dep_valid && cong_flags[dep_port];
    end

    // R8: nothing is marked without a departure
    a_r8_mark_needs_dep: assert property (@(posedge clk) disable iff (!rst_n)
        !dep_valid |-> !dep_mark);

    // R1: the first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (cong_flags == '0 && !alloc_req && !cfg_err));
endmodule

// File: tb/test_fwd_cong_marker.sv
module test_fwd_cong_marker;
    localparam int NOUT = 4;
    localparam int NHOT = 4;
    localparam int OW   = 6;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cfg_we = 1'b0;
    logic [OW-1:0]           cfg_cold_thr = '0, cfg_hi_thr = '0, cfg_lo_thr = '0;
    logic [OW-1:0]           cold_occ = '0;
    logic [NHOT-1:0][OW-1:0] hot_occ = '0;
    logic [NHOT-1:0][1:0]    hot_port = '0;
    logic [NHOT-1:0]         hot_valid = '0;
    logic                    dep_valid = 1'b0;
    logic [1:0]              dep_port = '0;
    logic                    alloc_req, dep_mark, cfg_err;
    logic [NOUT-1:0]         cong_flags;

    int n_cmp = 0;
    int n_bad = 0;
    int b_cold = 10, b_hi = 12, b_lo = 4;
    logic b_err = 1'b0;
    logic armed = 1'b1;
    logic [NOUT-1:0] m_flags = '0;

    always #10 clk = ~clk;

    fwd_cong_marker i_fwd_cong_marker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_cold_thr(cfg_cold_thr), .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr),
        .cold_occ(cold_occ), .hot_occ(hot_occ), .hot_port(hot_port), .hot_valid(hot_valid),
        .dep_valid(dep_valid), .dep_port(dep_port), .alloc_req(alloc_req),
        .cong_flags(cong_flags), .dep_mark(dep_mark), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock with the model advanced from the inputs now driven
    task automatic tick();
        logic [NOUT-1:0] nf;
        logic exp_alloc;
        for (int p = 0; p < NOUT; p++) begin
            logic hh, al;
            hh = 1'b0; al = 1'b0;
            for (int q = 0; q < NHOT; q++) begin
                if (hot_valid[q] && int'(hot_port[q]) == p) begin
                    if (int'(hot_occ[q]) >= b_hi) hh = 1'b1;
                    if (int'(hot_occ[q]) >  b_lo) al = 1'b1;
                end
            end
            nf[p] = m_flags[p] ? al : hh;
        end
        exp_alloc = armed && (int'(cold_occ) > b_cold);
        armed = armed ? !(int'(cold_occ) > b_cold) : (int'(cold_occ) < b_cold);
        m_flags = nf;
        @(posedge clk);
        @(negedge clk);
        chk("R4/R5/R6/R7 flags", int'(cong_flags), int'(m_flags));
        chk("R2/R3 alloc_req", int'(alloc_req), int'(exp_alloc));
        for (int dp = 0; dp < NOUT; dp++) begin
            dep_valid = 1'b1;
            dep_port  = 2'(dp);
            #1;
            chk("R8 mark", int'(dep_mark), int'(m_flags[dp]));
        end
        dep_valid = 1'b0;
        #1;
        chk("R8 no departure", int'(dep_mark), 0);
    endtask

    task automatic cfg_write(input int c, input int h, input int l);
        cfg_cold_thr = OW'(c);
        cfg_hi_thr   = OW'(h);
        cfg_lo_thr   = OW'(l);
        cfg_we       = 1'b1;
        tick();
        cfg_we = 1'b0;
        if (l < h) begin
            b_cold = c; b_hi = h; b_lo = l; b_err = 1'b0;
        end else begin
            b_err = 1'b1;
        end
        chk("R9/R10 cfg_err", int'(cfg_err), int'(b_err));
    endtask

    task automatic cold_sweep();
        for (int v = 0; v <= 20; v++) begin cold_occ = OW'(v); tick(); end
        for (int v = 20; v >= 0; v--) begin cold_occ = OW'(v); tick(); end
        // R3: sitting at the threshold does not re-arm
        cold_occ = OW'(b_cold + 1); tick();
        cold_occ = OW'(b_cold);     tick();
        cold_occ = OW'(b_cold + 1); tick();
        cold_occ = OW'(b_cold - 1); tick();
        cold_occ = OW'(b_cold + 2); tick();
        cold_occ = '0; tick();
        tick();
    endtask

    task automatic port_ramp(input int p);
        hot_valid = '0;
        hot_occ   = '0;
        hot_port  = '0;
        hot_port[0]  = 2'(p);
        hot_valid[0] = 1'b1;
        for (int v = 0; v <= 16; v++) begin hot_occ[0] = OW'(v); tick(); end
        for (int v = 16; v >= 0; v--) begin hot_occ[0] = OW'(v); tick(); end
        hot_valid = '0;
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        dep_valid = 1'b1;
        #1;
        chk("R1 flags", int'(cong_flags), 0);
        chk("R1 alloc", int'(alloc_req), 0);
        chk("R1 err", int'(cfg_err), 0);
        chk("R1 mark", int'(dep_mark), 0);
        dep_valid = 1'b0;
        rst_n = 1'b1;
        tick();

        // R2, R3 with default cold threshold
        cold_sweep();

        // R4, R5, R6, R8 on each port with default hi/lo
        for (int p = 0; p < NOUT; p++) port_ramp(p);

        // R7: every valid mask and mapping rotation
        for (int rot = 0; rot < NOUT; rot++) begin
            for (int m = 0; m < 16; m++) begin
                for (int q = 0; q < NHOT; q++) begin
                    hot_port[q] = 2'((q + rot) % NOUT);
                    hot_occ[q]  = OW'(b_hi);
                end
                hot_valid = 4'(m);
                tick();
                hot_occ = '0;
                tick();
            end
        end

        // R5: two queues on one port, one at low threshold and one above
        hot_port  = '0;
        hot_valid = 4'b0011;
        hot_occ[0] = OW'(b_hi); hot_occ[1] = '0; tick();
        hot_occ[0] = OW'(b_lo); hot_occ[1] = OW'(b_lo + 1); tick();
        hot_occ[1] = OW'(b_lo); tick();
        hot_valid = '0; hot_occ = '0; tick();

        // R9: accepted write, new thresholds in effect
        cfg_write(3, 6, 2);
        cold_sweep();
        port_ramp(2);

        // R10: equal and inverted pairs are rejected and thresholds kept
        cfg_write(20, 7, 7);
        port_ramp(1);
        cfg_write(1, 5, 9);
        cold_sweep();
        port_ramp(3);

        // R9: valid write clears the error
        cfg_write(12, 40, 30);
        port_ramp(0);
        cold_sweep();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule